// File: doc/BRIEF.md
# SPI Transmit/Receive FIFO and Interrupt Unit

This block sits between a 32-bit register bus and an SPI shift engine. It owns two byte queues, one feeding bytes to the shifter and one collecting bytes from it. Software pushes single bytes through a transmit data address and pops single bytes through a receive data address. The shifter pulls transmit bytes and pushes received bytes through a simple strobe-and-data pair on each side.

A control register holds a self-clearing flush bit and a fill threshold for each queue. A status register reports both fill counts. A sticky event register collects queue conditions, overflow and underflow errors, end of transfer and chip-select release. Software clears an event bit by writing 1 to it. A mask register with the same bit layout selects which events drive the single interrupt output.

Top module: `spi_fifo_irq`

## Requirements
- R1: While reset is held, the control, fill-count, mask and event registers read as zero and `irq` is low.
- R2: Bytes written to the transmit data address (offset 4) leave on `tx_byte` in write order, one per `tx_pop`. The fill-count register reports the transmit count in bits 23:16.
- R3: Bytes pushed with `rx_push` are returned in arrival order by reads of the receive data address (offset 5), one byte per read. The fill-count register (offset 1) reports the receive count in bits 7:0.
- R4: A write to the transmit queue while it holds DEPTH bytes is dropped. The count and the head byte do not change, and event bit 10 is set.
- R5: A read of the empty receive queue returns zero and sets event bit 9.
- R6: A `tx_pop` on an empty transmit queue presents zero on `tx_byte` and sets event bit 11. An `rx_push` into a full receive queue is dropped and sets event bit 8.
- R7: Writing 1 to bit 31 (transmit) or bit 15 (receive) of the control register (offset 0) empties that queue. The bit reads 1 in the cycle after the write and 0 from the following cycle on.
- R8: One cycle after the condition holds, the event register (offset 3) shows receive-empty in bit 1, receive-full in bit 2, transmit-empty in bit 5 and transmit-full in bit 6.
- R9: Event bit 0 is set while the receive count is at or above the receive threshold (control bits 7:0). Event bit 4 is set while the transmit count is at or below the transmit threshold (control bits 23:16).
- R10: Writing 1 to an event bit clears it and writing 0 leaves it. A level condition that still holds sets its bit again one cycle later.
- R11: A `xfer_done` pulse sets event bit 12 and a `cs_idle` pulse sets event bit 13.
- R12: The mask register (offset 2) keeps only the defined bits (mask 0x3F77). `irq` is high exactly when a bit is set in both the event and mask registers, and it follows mask and event writes in the same cycle they take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at offset 5) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |
| tx_pop | input | 1 | Shifter takes the transmit head byte |
| tx_byte | output | 8 | Transmit head byte (zero when empty) |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| xfer_done | input | 1 | Transfer-complete pulse |
| cs_idle | input | 1 | Chip-select release pulse |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count shows up at the ports at once: a byte out of order on `tx_byte` or in the receive read data, or a wrong value in the fill-count register on the next read. The event register reports a wrong level or error decision one cycle after the access that caused it. The interrupt line reports a wrong mask in the same cycle. Because the flush bit stays visible for one cycle, a flush that never finishes, or one that finishes early, is seen at the control register read taken right after the write.

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        xfer_done,
  input  logic        cs_idle,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [2:0] A_CTRL = 3'd0, A_LVL = 3'd1, A_MASK = 3'd2,
                         A_EVT = 3'd3, A_TXD = 3'd4, A_RXD = 3'd5;
  localparam logic [13:0] EV_BITS = 14'h3F77;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [7:0]    tx_thr, rx_thr;
  logic          tx_flush, rx_flush;
  logic [13:0]   mask, evt, evt_set;

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_mask = reg_wr && reg_addr == A_MASK;
  wire wr_evt  = reg_wr && reg_addr == A_EVT;
  wire tx_wr   = reg_wr && reg_addr == A_TXD;
  wire rx_rd   = reg_rd && reg_addr == A_RXD;

  wire tx_full  = tx_cnt == FULL_CNT;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULL_CNT;
  wire rx_empty = rx_cnt == '0;

  wire tx_in  = tx_wr   && !tx_full  && !tx_flush;
  wire tx_out = tx_pop  && !tx_empty && !tx_flush;
  wire rx_in  = rx_push && !rx_full  && !rx_flush;
  wire rx_out = rx_rd   && !rx_empty && !rx_flush;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[30:24], reg_wdata[14:8]};

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= reg_wdata[7:0];
    if (rx_in) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in)  tx_wp <= tx_wp + 1'b1;
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in)  rx_wp <= rx_wp + 1'b1;
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flush <= 1'b0; rx_flush <= 1'b0;
      tx_thr <= '0; rx_thr <= '0;
      mask <= '0;
    end else begin
      tx_flush <= wr_ctrl && reg_wdata[31];
      rx_flush <= wr_ctrl && reg_wdata[15];
      if (wr_ctrl) begin
        tx_thr <= reg_wdata[23:16];
        rx_thr <= reg_wdata[7:0];
      end
      if (wr_mask) mask <= reg_wdata[13:0] & EV_BITS;
    end
  end

  always_comb begin
    evt_set     = '0;
    evt_set[0]  = 8'(rx_cnt) >= rx_thr;
    evt_set[1]  = rx_empty;
    evt_set[2]  = rx_full;
    evt_set[4]  = 8'(tx_cnt) <= tx_thr;
    evt_set[5]  = tx_empty;
    evt_set[6]  = tx_full;
    evt_set[8]  = rx_push && rx_full;
    evt_set[9]  = rx_rd && rx_empty;
    evt_set[10] = tx_wr && tx_full;
    evt_set[11] = tx_pop && tx_empty;
    evt_set[12] = xfer_done;
    evt_set[13] = cs_idle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= '0;
    else        evt <= (evt & ~(wr_evt ? reg_wdata[13:0] : 14'h0)) | evt_set;
  end

  assign tx_byte = tx_empty ? 8'h00 : tx_mem[tx_rp];
  assign irq     = |(evt & mask);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {tx_flush, 7'b0, tx_thr, rx_flush, 7'b0, rx_thr};
      A_LVL:   reg_rdata = {8'b0, 8'(tx_cnt), 8'b0, 8'(rx_cnt)};
      A_MASK:  reg_rdata = {18'b0, mask};
      A_EVT:   reg_rdata = {18'b0, evt};
      A_RXD:   reg_rdata = {24'b0, rx_empty ? 8'h00 : rx_mem[rx_rp]};
      default: reg_rdata = '0;
    endcase
  end

  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL_CNT && rx_cnt <= FULL_CNT); // R2
  AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && tx_full) |=> (evt[10] && tx_cnt == FULL_CNT)); // R4
  AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |=> evt[9]); // R5
  AST_FLUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_flush && !(wr_ctrl && reg_wdata[31])) |=> (!tx_flush && tx_cnt == '0)); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && reg_wdata[13:0] == 14'h0) |=> !irq); // R12
endmodule

// File: tb/spi_fifo_irq_test.sv
module spi_fifo_irq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        tx_pop, rx_push, xfer_done, cs_idle, irq;
  logic [7:0]  tx_byte, rx_byte;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  spi_fifo_irq uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_byte(tx_byte), .rx_push(rx_push), .rx_byte(rx_byte),
    .xfer_done(xfer_done), .cs_idle(cs_idle), .irq(irq)
  );

  // op 0: write TX data, 1: shifter pop and expect, 2: shifter push, 3: read RX data and expect
  localparam logic [9:0] VEC [12] = '{
    {2'd0, 8'h11}, {2'd0, 8'h22}, {2'd0, 8'h33}, {2'd1, 8'h11},
    {2'd0, 8'h44}, {2'd1, 8'h22}, {2'd1, 8'h33}, {2'd1, 8'h44},
    {2'd2, 8'h9A}, {2'd2, 8'hBC}, {2'd3, 8'h9A}, {2'd3, 8'hBC}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pop(output logic [7:0] d);
    tx_pop = 1'b1;
    #1 d = tx_byte;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic push(input logic [7:0] d);
    rx_push = 1'b1; rx_byte = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    tx_pop = 0; rx_push = 0; rx_byte = 0; xfer_done = 0; cs_idle = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    rd(3'd0, r); chk("R1 ctrl", r, 0);
    rd(3'd1, r); chk("R1 level", r, 0);
    rd(3'd2, r); chk("R1 mask", r, 0);
    rd(3'd3, r); chk("R1 events", r, 0);
    rst_n = 1'b1;
    idle(); idle();
    rd(3'd3, r); chk("R8 R9 idle events", r, 32'h33);

    for (int i = 0; i < 12; i++) begin
      case (VEC[i][9:8])
        2'd0: wr(3'd4, {24'b0, VEC[i][7:0]});
        2'd1: begin pop(b); chk("R2 tx order", {24'b0, b}, {24'b0, VEC[i][7:0]}); end
        2'd2: push(VEC[i][7:0]);
        default: begin rd(3'd5, r); chk("R3 rx order", r, {24'b0, VEC[i][7:0]}); end
      endcase
    end
    rd(3'd1, r); chk("R2 R3 drained", r, 0);

    for (int i = 0; i < 64; i++) wr(3'd4, i);
    idle();
    rd(3'd1, r); chk("R2 tx count 64", r, 32'h0040_0000);
    rd(3'd3, r); chk("R8 tx full", {31'b0, r[6]}, 1);
    wr(3'd4, 32'hEE);
    idle();
    rd(3'd1, r); chk("R4 count kept", r, 32'h0040_0000);
    rd(3'd3, r); chk("R4 tx overrun", {31'b0, r[10]}, 1);
    pop(b); chk("R4 head kept", {24'b0, b}, 0);

    wr(3'd0, 32'h8000_0000);
    rd(3'd0, r); chk("R7 tx flush busy", r, 32'h8000_0000);
    rd(3'd0, r); chk("R7 tx flush done", r, 0);
    rd(3'd1, r); chk("R7 tx emptied", r, 0);

    pop(b); chk("R6 tx underrun data", {24'b0, b}, 0);
    idle();
    rd(3'd3, r); chk("R6 tx underrun flag", {31'b0, r[11]}, 1);

    for (int i = 0; i < 65; i++) push(8'(i + 1));
    idle();
    rd(3'd1, r); chk("R6 rx count 64", r, 32'h0000_0040);
    rd(3'd3, r); chk("R6 rx overrun", {30'b0, r[8], r[2]}, 3);
    rd(3'd5, r); chk("R6 rx head", r, 1);
    wr(3'd0, 32'h0000_8000);
    rd(3'd0, r); chk("R7 rx flush busy", r, 32'h0000_8000);
    rd(3'd1, r); chk("R7 rx emptied", r, 0);

    rd(3'd5, r); chk("R5 empty read", r, 0);
    idle();
    rd(3'd3, r); chk("R5 rx underrun", {31'b0, r[9]}, 1);

    wr(3'd3, 32'h0);
    idle();
    rd(3'd3, r); chk("R10 zero write", {31'b0, r[9]}, 1);
    wr(3'd3, 32'h200);
    idle();
    rd(3'd3, r); chk("R10 cleared", {31'b0, r[9]}, 0);
    wr(3'd3, 32'h2);
    idle();
    rd(3'd3, r); chk("R10 level resets", {31'b0, r[1]}, 1);

    wr(3'd0, 32'h0002_0004);
    push(8'hA1); push(8'hA2); push(8'hA3);
    wr(3'd3, 32'h3FFF);
    idle();
    rd(3'd3, r); chk("R9 rx below", {31'b0, r[0]}, 0);
    push(8'hA4);
    idle();
    rd(3'd3, r); chk("R9 rx at", {31'b0, r[0]}, 1);
    wr(3'd4, 32'h1); wr(3'd4, 32'h2); wr(3'd4, 32'h3);
    wr(3'd3, 32'h3FFF);
    idle();
    rd(3'd3, r); chk("R9 tx above", {31'b0, r[4]}, 0);
    pop(b);
    idle();
    rd(3'd3, r); chk("R9 tx at", {31'b0, r[4]}, 1);

    xfer_done = 1'b1; idle(); xfer_done = 1'b0;
    cs_idle = 1'b1; idle(); cs_idle = 1'b0;
    rd(3'd3, r); chk("R11 done cs", {30'b0, r[13], r[12]}, 3);

    chk("R12 masked off", {31'b0, irq}, 0);
    wr(3'd2, 32'h1000);
    chk("R12 irq on", {31'b0, irq}, 1);
    wr(3'd3, 32'h1000);
    chk("R12 irq cleared", {31'b0, irq}, 0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, r); chk("R12 mask bits", r, 32'h3F77);
    chk("R12 irq any", {31'b0, irq}, 1);
    wr(3'd2, 32'h0);
    chk("R12 irq off", {31'b0, irq}, 0);

    finish_run();
  end
endmodule